// File: doc/BRIEF.md
# Positional Multi-Level Interrupt Arbiter

This block picks which device on a chained peripheral bus is serviced when the single interrupt-handling processor acknowledges an interrupt. Each of `N_DEV` devices can raise a request tagged with one of four priority levels, and it offers a vector that points to its service routine. The processor supplies its current priority, so only requests above that value can compete.

Arbitration uses two keys. The level is compared first, and a higher number wins. Among requests at the winning level, the device with the lowest chain index wins, because that device sits nearest the processor. When the processor raises its acknowledge line, the arbiter samples the requests on that clock edge. It then pulses a one-hot grant to the winner for one cycle and presents the winner's vector with a valid strobe in the same cycle. The acknowledge line must drop before another arbitration can begin. Devices only hold a request and a vector; all decision logic sits here on the processor side.

Top module: `irq_pos_arbiter`

## Requirements
- R1: After reset, `grant`, `vec_valid` and `vec_out` are all zero.
- R2: If eligible requests exist at different levels, the request with the numerically highest level is granted, whatever its chain index.
- R3: If several eligible requests share the winning level, the lowest chain index is granted.
- R4: A request is eligible only when its level is strictly greater than `cur_mask`, so a level-0 request is never eligible. If nothing is eligible when acknowledge is sampled, no grant is issued and `vec_valid` stays low.
- R5: At most one `grant` bit is ever high. A grant lasts exactly one cycle and is issued in the cycle after acknowledge is first sampled high.
- R6: `vec_out` equals the granted device's vector with bit 0 forced to zero. `vec_valid` is high in the grant cycle, and `vec_out` keeps that value until the next grant.
- R7: While acknowledge stays high after an arbitration, no further grant is issued, even if new requests appear. A new arbitration needs acknowledge to go low first.
- R8: A request that is withdrawn on the cycle acknowledge is sampled does not take part. The next eligible request wins instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | N_DEV | Request line per device; index 0 is nearest the processor |
| dev_lvl | input | 2*N_DEV | Level per device; device i uses bits [2i+1:2i] |
| dev_vec | input | 9*N_DEV | Vector per device; device i uses bits [9i+8:9i] |
| cur_mask | input | 2 | Processor's current priority; a request must be above it to compete |
| iack | input | 1 | Interrupt acknowledge from the processor |
| grant | output | N_DEV | One-hot, one-cycle grant to the winning device |
| vec_out | output | 9 | Latched vector of the granted device, bit 0 cleared |
| vec_valid | output | 1 | High for the cycle in which `vec_out` carries a new vector |

## Verification
Two functions can meet in the same cycle: request withdrawal and the sampling of acknowledge. The bench drops the highest-priority request on the same edge at which acknowledge is first seen high. It then checks that the grant and vector go to the next-best device, and not to the one that withdrew. A second overlap arises when new high-level requests appear while acknowledge is held. For that case the bench keeps `grant` and `vec_valid` under watch for several cycles and expects them to stay quiet, and it then requires the new winner once acknowledge has been released and raised again.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 4;
  localparam int VEC_W   = 9;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_HOLD = 1'b1
  } ack_state_e;
endpackage

// File: rtl/irq_elig.sv
module irq_elig
  import irq_arb_pkg::*;
#(
  parameter int N_DEV = 8
) (
  input  logic [N_DEV-1:0]       req,
  input  logic [N_DEV*LVL_W-1:0] lvl,
  input  logic [LVL_W-1:0]       mask,
  output logic [N_DEV-1:0]       elig
);
  // A device competes only if its level is strictly above the processor's current priority.
  for (genvar g = 0; g < N_DEV; g++) begin : g_dev
    assign elig[g] = req[g] && (lvl[g*LVL_W +: LVL_W] > mask);
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int N_DEV = 8,
  localparam int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic [N_DEV-1:0]       elig,
  input  logic [N_DEV*LVL_W-1:0] lvl,
  output logic                   found,
  output logic [IDX_W-1:0]       idx
);
  logic [LVL_W-1:0] top_lvl;

  // First key: the highest level that any eligible device carries.
  always_comb begin
    top_lvl = '0;
    found   = 1'b0;
    for (int l = 0; l < NUM_LVL; l++) begin
      for (int i = 0; i < N_DEV; i++) begin
        if (elig[i] && (lvl[i*LVL_W +: LVL_W] == LVL_W'(l))) begin
          top_lvl = LVL_W'(l);
          found   = 1'b1;
        end
      end
    end
  end

  // Second key: the nearest device at that level. The downward scan leaves the lowest index.
  always_comb begin
    idx = '0;
    for (int i = N_DEV - 1; i >= 0; i--) begin
      if (elig[i] && (lvl[i*LVL_W +: LVL_W] == top_lvl)) begin
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
  import irq_arb_pkg::*;
#(
  parameter int N_DEV = 8,
  localparam int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   iack,
  input  logic                   found,
  input  logic [IDX_W-1:0]       idx,
  input  logic [N_DEV*VEC_W-1:0] dev_vec,
  output logic [N_DEV-1:0]       grant,
  output logic [VEC_W-1:0]       vec_out,
  output logic                   vec_valid
);
  ack_state_e       st_q;
  logic [N_DEV-1:0] grant_q;
  logic [VEC_W-1:0] vec_q;
  logic             valid_q;
  logic [VEC_W-1:0] win_vec;

  assign win_vec = dev_vec[idx*VEC_W +: VEC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_IDLE;
      grant_q <= '0;
      vec_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      grant_q <= '0;
      valid_q <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (iack) begin
            st_q <= S_HOLD;
            if (found) begin
              grant_q <= N_DEV'(1) << idx;
              vec_q   <= {win_vec[VEC_W-1:1], 1'b0};
              valid_q <= 1'b1;
            end
          end
        end
        default: begin
          if (!iack) st_q <= S_IDLE;
        end
      endcase
    end
  end

  assign grant     = grant_q;
  assign vec_out   = vec_q;
  assign vec_valid = valid_q;

  // R5
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(grant_q));
  // R5
  grant_pulse_chk: assert property (@(posedge clk) disable iff (rst) (|grant_q) |=> (grant_q == '0));
  // R5
  grant_after_ack_chk: assert property (@(posedge clk) disable iff (rst) (|grant_q) |-> $past(iack));
  // R6
  vec_align_chk: assert property (@(posedge clk) disable iff (rst) valid_q |-> !vec_q[0]);
  // R6
  vec_hold_chk: assert property (@(posedge clk) disable iff (rst) !valid_q |=> (valid_q || $stable(vec_q)));
  // R7
  hold_no_grant_chk: assert property (@(posedge clk) disable iff (rst) (st_q == S_HOLD) |=> (grant_q == '0));
endmodule

// File: rtl/irq_pos_arbiter.sv
module irq_pos_arbiter
  import irq_arb_pkg::*;
#(
  parameter int N_DEV = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_DEV-1:0]       dev_req,
  input  logic [N_DEV*LVL_W-1:0] dev_lvl,
  input  logic [N_DEV*VEC_W-1:0] dev_vec,
  input  logic [LVL_W-1:0]       cur_mask,
  input  logic                   iack,
  output logic [N_DEV-1:0]       grant,
  output logic [VEC_W-1:0]       vec_out,
  output logic                   vec_valid
);
  localparam int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1;

  logic [N_DEV-1:0] elig;
  logic             found;
  logic [IDX_W-1:0] idx;

  irq_elig #(.N_DEV(N_DEV)) u_elig (
    .req (dev_req),
    .lvl (dev_lvl),
    .mask(cur_mask),
    .elig(elig)
  );

  irq_pick #(.N_DEV(N_DEV)) u_pick (
    .elig (elig),
    .lvl  (dev_lvl),
    .found(found),
    .idx  (idx)
  );

  irq_ack_fsm #(.N_DEV(N_DEV)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .iack     (iack),
    .found    (found),
    .idx      (idx),
    .dev_vec  (dev_vec),
    .grant    (grant),
    .vec_out  (vec_out),
    .vec_valid(vec_valid)
  );

  // R4
  grant_eligible_chk: assert property (@(posedge clk) disable iff (rst)
    (|grant) |-> ((grant & $past(dev_req)) == grant));
  // R5
  valid_matches_grant_chk: assert property (@(posedge clk) disable iff (rst) vec_valid == (|grant));
endmodule

// File: tb/tb_irq_pos_arbiter.sv
`timescale 1ns/1ps
module tb_irq_pos_arbiter;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   dev_req = '0;
  logic [2*N-1:0] dev_lvl = '0;
  logic [9*N-1:0] dev_vec;
  logic [1:0]     cur_mask = '0;
  logic           iack = 1'b0;
  logic [N-1:0]   grant;
  logic [8:0]     vec_out;
  logic           vec_valid;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_pos_arbiter #(.N_DEV(N)) dut (
    .clk(clk), .rst(rst), .dev_req(dev_req), .dev_lvl(dev_lvl), .dev_vec(dev_vec),
    .cur_mask(cur_mask), .iack(iack), .grant(grant), .vec_out(vec_out), .vec_valid(vec_valid)
  );

  // Each vector is odd, so the bench also sees that bit 0 gets cleared.
  function automatic logic [8:0] raw_vec(int i);
    return 9'(i * 34 + 3);
  endfunction

  initial begin
    for (int i = 0; i < N; i++) dev_vec[i*9 +: 9] = raw_vec(i);
  end

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {req, lvl, mask, expected index (16 = no grant)}
  localparam logic [30:0] TBL [8] = '{
    {8'h01, 16'h5555, 2'd0, 5'd0},
    {8'hA0, 16'hC400, 2'd0, 5'd7},
    {8'h34, 16'hAAAA, 2'd1, 5'd2},
    {8'hFF, 16'hAAAA, 2'd2, 5'd16},
    {8'h82, 16'hC008, 2'd2, 5'd7},
    {8'h06, 16'hFFFF, 2'd3, 5'd16},
    {8'hC0, 16'hFFFF, 2'd1, 5'd6},
    {8'h01, 16'h0000, 2'd0, 5'd16}
  };

  // Check the grant cycle, then the cycle after it. Acknowledge is released when it returns.
  task automatic ack_and_check(int exp, string tag);
    logic [N-1:0] eg;
    logic [8:0]   ev;
    eg = (exp < N) ? (N'(1) << exp) : '0;
    ev = (exp < N) ? (raw_vec(exp) & 9'h1FE) : 9'h0;
    iack = 1'b1;
    @(negedge clk);
    chk(grant == eg, {tag, " grant"}, 16'(grant), 16'(eg));
    chk(vec_valid == (exp < N), {tag, " valid"}, 16'(vec_valid), 16'(exp < N));
    if (exp < N) chk(vec_out == ev, {tag, " vector R6"}, 16'(vec_out), 16'(ev));
    @(negedge clk);
    chk(grant == '0 && !vec_valid, {tag, " pulse R5"}, 16'(grant), 16'h0);
    iack = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(grant == '0 && !vec_valid && vec_out == '0, "R1 reset", 16'(vec_out), 16'h0);

    // R2 R3 R4: table walk
    for (int k = 0; k < 8; k++) begin
      dev_req  = TBL[k][30:23];
      dev_lvl  = TBL[k][22:7];
      cur_mask = TBL[k][6:5];
      ack_and_check(int'(TBL[k][4:0]), $sformatf("R2/R3/R4 row%0d", k));
    end

    // R6: the vector holds after the strobe. The last winner was device 6.
    chk(vec_out == (raw_vec(6) & 9'h1FE), "R6 hold", 16'(vec_out), 16'(raw_vec(6) & 9'h1FE));

    // R7: new requests while acknowledge is still held
    dev_req = 8'h01; dev_lvl = 16'hFFFF; cur_mask = 2'd0;
    iack = 1'b1;
    @(negedge clk);
    chk(grant == 8'h01, "R7 first grant", 16'(grant), 16'h01);
    dev_req = 8'h30;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(grant == '0 && !vec_valid, "R7 no regrant", 16'(grant), 16'h0);
    end
    iack = 1'b0;
    @(negedge clk);
    @(negedge clk);
    ack_and_check(4, "R7 after release");

    // R8: the top request withdraws on the cycle acknowledge is sampled
    dev_req = 8'h09; dev_lvl = 16'h00C3; cur_mask = 2'd0;
    repeat (2) @(negedge clk);
    dev_req = 8'h08;
    ack_and_check(3, "R8 withdraw");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule